// File: doc/BRIEF.md
# Neighbour-Pin Input Selector with Deglitch Filter

This block conditions the logic inputs of an array of pins. For every pin it forms two logic signals, A and B. Each one is taken from that pin's own sampled input, from a pin up to three places above or below it, or from the pin's own driven output fed back after output-enable gating. A per-pin peripheral sits next to the block and consumes A and B. The processor-facing input value of each pin is the conditioned A signal.

A bank of four shared filter settings is broadcast to every pin. Each setting carries an enable, a 2-bit run-length code and a one-cycle sample strobe. Each pin picks one setting with a 2-bit selector. When the picked setting is enabled, A and B each pass through a deglitch filter that is local to the pin. The filter's output moves to a new level only when a run of consecutive strobed samples all show that level. When the setting is disabled, the selected sources pass straight through in the same cycle. Pins are numbered upward. An even pin's +1 neighbour is the odd pin of its pair, and an odd pin's -1 neighbour is the even pin of its pair.

Top module: `pin_input_cond`

## Requirements
- R1: Source code 0 selects the pin's own `pin_in` bit.
- R2: Source codes 1, 2 and 3 select the pin at offset +1, +2 and +3. Codes 5, 6 and 7 select the pin at offset -1, -2 and -3. So for pin pair 2k/2k+1, code 1 on pin 2k reads pin 2k+1, and code 5 on pin 2k+1 reads pin 2k.
- R3: A neighbour offset that lands outside pins 0..NUM_PINS-1 reads as 0.
- R4: Source code 4 selects the pin's own `drv_val` bit ANDed with its `drv_en` bit.
- R5: Each pin's 2-bit `set_sel` field (bits 2p+1:2p) picks one of the four settings. When that setting's `glb_en` bit is 0, `a_out` and `b_out` equal the selected sources in the same cycle.
- R6: The 2-bit size field of setting k is `glb_size[2k+1:2k]`. Codes 0, 1, 2 and 3 give run lengths of 2, 3, 5 and 8 samples.
- R7: With the picked setting enabled, the filter takes one sample at each clock edge where that setting's `glb_tick` bit is 1. The output takes a new level at that edge only if the newest L samples, including the one just taken, all equal that level. Otherwise the output holds. While the setting is disabled, the filter output register follows the source every cycle, and samples are still taken on ticks.
- R8: `in_out[p]` always equals `a_out[p]`.
- R9: A synchronous active-high `rst` clears every sample history and every filter output to 0.
- R10: Source codes for A (`sel_a[3p+2:3p]`) and B (`sel_b[3p+2:3p]`) are applied independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Sampled input level of each pin |
| drv_val | input | NUM_PINS | Output value each pin drives |
| drv_en | input | NUM_PINS | Output enable of each pin |
| sel_a | input | 3*NUM_PINS | Source code for A, 3 bits per pin |
| sel_b | input | 3*NUM_PINS | Source code for B, 3 bits per pin |
| set_sel | input | 2*NUM_PINS | Filter setting choice, 2 bits per pin |
| glb_en | input | 4 | Enable bit of each shared setting |
| glb_size | input | 8 | Run-length code of each shared setting, 2 bits each |
| glb_tick | input | 4 | Sample strobe of each shared setting |
| a_out | output | NUM_PINS | Conditioned A per pin |
| b_out | output | NUM_PINS | Conditioned B per pin |
| in_out | output | NUM_PINS | Processor-facing input per pin |

## Verification
The bench first drives random source codes, pin levels and drive values with every setting disabled. This separates the own-pin, neighbour, edge and feedback selections from one another, and A from B. It then holds each run-length code in turn and toggles the pins at a rate that produces glitches both shorter and longer than the run. This shows whether the filter moves on exactly L agreeing strobed samples and not on L-1. A final phase mixes enabled and disabled settings, random strobes and a mid-run reset. This checks per-pin setting choice and reset clearing against a queue-based model that is compared on every clock.

// File: rtl/nbsel_pkg.sv
package nbsel_pkg;

    localparam int NSET   = 4;
    localparam int CODE_W = 3;
    localparam int SIZE_W = 2;
    localparam int PICK_W = $clog2(NSET);
    localparam int HIST_W = 8;
    localparam int REACH  = 3;
    localparam int WIN_W  = 2 * REACH + 1;

    typedef enum logic [CODE_W-1:0] {
        SRC_OWN = 3'd0,
        SRC_UP1 = 3'd1,
        SRC_UP2 = 3'd2,
        SRC_UP3 = 3'd3,
        SRC_FB  = 3'd4,
        SRC_DN1 = 3'd5,
        SRC_DN2 = 3'd6,
        SRC_DN3 = 3'd7
    } src_code_t;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] size;
        logic              tick;
    } flt_cfg_t;

    function automatic int run_len(input logic [SIZE_W-1:0] size);
        case (size)
            2'd0:    return 2;
            2'd1:    return 3;
            2'd2:    return 5;
            default: return 8;
        endcase
    endfunction

    function automatic logic [HIST_W-1:0] run_mask(input logic [SIZE_W-1:0] size);
        logic [HIST_W-1:0] m;
        m = '0;
        for (int i = 0; i < HIST_W; i++) begin
            if (i < run_len(size)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nbsel_src_mux.sv
module nbsel_src_mux
    import nbsel_pkg::*;
(
    input  logic [WIN_W-1:0]  win,
    input  logic              fb,
    input  logic [CODE_W-1:0] code,
    output logic              sel_o
);

    always_comb begin
        case (src_code_t'(code))
            SRC_OWN: sel_o = win[REACH];
            SRC_UP1: sel_o = win[REACH+1];
            SRC_UP2: sel_o = win[REACH+2];
            SRC_UP3: sel_o = win[REACH+3];
            SRC_FB:  sel_o = fb;
            SRC_DN1: sel_o = win[REACH-1];
            SRC_DN2: sel_o = win[REACH-2];
            default: sel_o = win[REACH-3];
        endcase
    end

    // R1: own-pin code routes the window centre
    always_comb begin
        if (code == 3'd0) p_own_route_r1: assert (sel_o == win[REACH]);
    end

    // R4: feedback code routes the gated drive bit
    always_comb begin
        if (code == 3'd4) p_fb_route_r4: assert (sel_o == fb);
    end

endmodule

// File: rtl/nbsel_deglitch.sv
module nbsel_deglitch
    import nbsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flt_cfg_t cfg,
    input  logic     src,
    output logic     flt_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nx;
    logic [HIST_W-1:0] mask;
    logic              agree;
    logic              filt_q;

    always_comb begin
        hist_nx = {hist_q[HIST_W-2:0], src};
        mask    = run_mask(cfg.size);
        agree   = ((hist_nx & mask) == mask) || ((hist_nx & mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            filt_q <= 1'b0;
        end else begin
            if (cfg.tick) hist_q <= hist_nx;
            if (!cfg.en) filt_q <= src;
            else if (cfg.tick && agree) filt_q <= src;
        end
    end

    assign flt_o = cfg.en ? filt_q : src;

    // R7: no strobe, no movement while filtering
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !cfg.tick) |=> $stable(filt_q));

    // R7: a split run holds the level
    p_hold_split_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.tick && !agree) |=> $stable(filt_q));

    // R7: a unanimous run adopts the sampled level
    p_take_level_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.tick && agree) |=> (filt_q == $past(src)));

endmodule

// File: rtl/nbsel_pin.sv
module nbsel_pin
    import nbsel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIN_W-1:0]       win,
    input  logic                   fb,
    input  logic [CODE_W-1:0]      code_a,
    input  logic [CODE_W-1:0]      code_b,
    input  logic [PICK_W-1:0]      pick,
    input  logic [NSET-1:0]        bank_en,
    input  logic [NSET*SIZE_W-1:0] bank_size,
    input  logic [NSET-1:0]        bank_tick,
    output logic                   a_o,
    output logic                   b_o
);

    flt_cfg_t           cfg;
    logic [1:0]         raw;
    logic [1:0]         cond;
    logic [1:0][CODE_W-1:0] codes;

    always_comb begin
        cfg.en   = bank_en[pick];
        cfg.size = bank_size[pick*SIZE_W +: SIZE_W];
        cfg.tick = bank_tick[pick];
    end

    assign codes[0] = code_a;
    assign codes[1] = code_b;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        nbsel_src_mux u_mux (
            .win   (win),
            .fb    (fb),
            .code  (codes[c]),
            .sel_o (raw[c])
        );
        nbsel_deglitch u_flt (
            .clk   (clk),
            .rst   (rst),
            .cfg   (cfg),
            .src   (raw[c]),
            .flt_o (cond[c])
        );
    end

    assign a_o = cond[0];
    assign b_o = cond[1];

    // R5: a disabled setting leaves the chosen source untouched
    always_comb begin
        if (!cfg.en) p_bypass_r5: assert (a_o == raw[0] && b_o == raw[1]);
    end

endmodule

// File: rtl/pin_input_cond.sv
module pin_input_cond
    import nbsel_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS-1:0]        drv_val,
    input  logic [NUM_PINS-1:0]        drv_en,
    input  logic [3*NUM_PINS-1:0]      sel_a,
    input  logic [3*NUM_PINS-1:0]      sel_b,
    input  logic [2*NUM_PINS-1:0]      set_sel,
    input  logic [3:0]                 glb_en,
    input  logic [7:0]                 glb_size,
    input  logic [3:0]                 glb_tick,
    output logic [NUM_PINS-1:0]        a_out,
    output logic [NUM_PINS-1:0]        b_out,
    output logic [NUM_PINS-1:0]        in_out
);

    localparam int EXT_W = NUM_PINS + 2 * REACH;

    logic [EXT_W-1:0]    ext;
    logic [NUM_PINS-1:0] fb_bits;

    assign ext     = {{REACH{1'b0}}, pin_in, {REACH{1'b0}}};
    assign fb_bits = drv_val & drv_en;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        nbsel_pin u_pin (
            .clk       (clk),
            .rst       (rst),
            .win       (ext[p +: WIN_W]),
            .fb        (fb_bits[p]),
            .code_a    (sel_a[p*CODE_W +: CODE_W]),
            .code_b    (sel_b[p*CODE_W +: CODE_W]),
            .pick      (set_sel[p*PICK_W +: PICK_W]),
            .bank_en   (glb_en),
            .bank_size (glb_size),
            .bank_tick (glb_tick),
            .a_o       (a_out[p]),
            .b_o       (b_out[p])
        );
    end

    assign in_out = a_out;

    // R8: processor-side value mirrors the conditioned A
    always_comb begin
        p_in_is_a_r8: assert (in_out == a_out);
    end

endmodule

// File: tb/pin_input_cond_tb_top.sv
module pin_input_cond_tb_top;

    localparam int NP = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   pin_in = '0, drv_val = '0, drv_en = '0;
    logic [3*NP-1:0] sel_a = '0, sel_b = '0;
    logic [2*NP-1:0] set_sel = '0;
    logic [3:0]      glb_en = '0, glb_tick = '0;
    logic [7:0]      glb_size = '0;
    logic [NP-1:0]   a_out, b_out, in_out;

    int n_chk = 0, n_bad = 0, phase = 0;
    bit comparing = 0, done = 0;

    int hq[NP][2][$];
    bit fq[NP][2];

    always #5 clk = ~clk;

    pin_input_cond #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .drv_val(drv_val), .drv_en(drv_en),
        .sel_a(sel_a), .sel_b(sel_b), .set_sel(set_sel), .glb_en(glb_en),
        .glb_size(glb_size), .glb_tick(glb_tick), .a_out(a_out), .b_out(b_out),
        .in_out(in_out)
    );

    function automatic bit src_of(int p, int code);
        int q;
        if (code == 4) return drv_val[p] & drv_en[p];
        q = (code < 4) ? p + code : p - (code - 4);
        if (q < 0 || q >= NP) return 1'b0;
        return pin_in[q];
    endfunction

    function automatic int code_of(int p, int ch);
        return ch ? int'(sel_b[p*3 +: 3]) : int'(sel_a[p*3 +: 3]);
    endfunction

    function automatic int len_of(int k);
        int s;
        s = int'(glb_size[k*2 +: 2]);
        return (s == 0) ? 2 : (s == 1) ? 3 : (s == 2) ? 5 : 8;
    endfunction

    task automatic check(bit act, bit exp, string tag, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each clock edge
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (rst) begin
                    hq[p][ch].delete();
                    for (int i = 0; i < 8; i++) hq[p][ch].push_front(0);
                    fq[p][ch] = 0;
                end else begin
                    int k, L;
                    bit s, same;
                    k = int'(set_sel[p*2 +: 2]);
                    s = src_of(p, code_of(p, ch));
                    if (glb_tick[k]) begin
                        hq[p][ch].push_front(int'(s));
                        while (hq[p][ch].size() > 8) void'(hq[p][ch].pop_back());
                    end
                    if (!glb_en[k]) fq[p][ch] = s;
                    else if (glb_tick[k]) begin
                        L = len_of(k);
                        same = 1;
                        for (int i = 0; i < L; i++) if (hq[p][ch][i] != int'(s)) same = 0;
                        if (same) fq[p][ch] = s;
                    end
                end
            end
        end
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (comparing) begin
            for (int p = 0; p < NP; p++) begin
                for (int ch = 0; ch < 2; ch++) begin
                    int k, code, q;
                    bit e, act;
                    string tag;
                    k = int'(set_sel[p*2 +: 2]);
                    e = glb_en[k];
                    code = code_of(p, ch);
                    q = (code < 4) ? p + code : p - (code - 4);
                    act = ch ? b_out[p] : a_out[p];
                    if (e) tag = (phase == 3) ? "R6" : "R7";
                    else if (phase == 4) tag = "R5";
                    else if (phase == 2 && ch == 1) tag = "R10";
                    else if (code == 0) tag = "R1";
                    else if (code == 4) tag = "R4";
                    else if (q < 0 || q >= NP) tag = "R3";
                    else tag = "R2";
                    check(act, e ? fq[p][ch] : src_of(p, code), tag, ch ? "b_out" : "a_out");
                end
                check(in_out[p], a_out[p], "R8", "in_out");
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // reset state: all settings on, inputs high, filters read 0 (R9)
        glb_en = 4'hF;
        glb_size = 8'hFF;
        pin_in = '1;
        repeat (3) step();
        @(negedge clk);
        for (int p = 0; p < NP; p++) check(a_out[p], 1'b0, "R9", "a_out after reset");
        step();
        rst = 1'b0;
        comparing = 1;

        // phase 2: pure selection with every setting disabled
        phase = 2;
        glb_en = '0;
        for (int c = 0; c < 400; c++) begin
            pin_in = NP'($urandom);
            drv_val = NP'($urandom);
            drv_en = NP'($urandom);
            sel_a = (3*NP)'({$urandom, $urandom});
            sel_b = (3*NP)'({$urandom, $urandom});
            set_sel = (2*NP)'($urandom);
            glb_tick = 4'($urandom);
            step();
        end

        // phase 3: each run length, glitchy inputs on own pin
        phase = 3;
        sel_a = '0;
        sel_b = '0;
        glb_en = 4'hF;
        for (int sz = 0; sz < 4; sz++) begin
            glb_size = {4{2'(sz)}};
            for (int c = 0; c < 500; c++) begin
                for (int p = 0; p < NP; p++) if ($urandom_range(0, 5) == 0) pin_in[p] = ~pin_in[p];
                glb_tick = (c % 2 == 0) ? 4'hF : 4'h0;
                set_sel = (2*NP)'($urandom);
                step();
            end
        end

        // phase 4: mixed settings, random strobes, mid-run reset
        phase = 4;
        for (int c = 0; c < 1500; c++) begin
            if ($urandom_range(0, 3) == 0) pin_in = NP'($urandom);
            drv_val = NP'($urandom);
            drv_en = NP'($urandom);
            if ($urandom_range(0, 15) == 0) begin
                sel_a = (3*NP)'({$urandom, $urandom});
                sel_b = (3*NP)'({$urandom, $urandom});
                set_sel = (2*NP)'($urandom);
                glb_en = 4'($urandom);
                glb_size = 8'($urandom);
            end
            glb_tick = 4'($urandom) & 4'($urandom);
            if (c == 700) begin
                glb_en = 4'hF;
                pin_in = '1;
                sel_a = '0;
                rst = 1'b1;
                step();
                @(negedge clk);
                for (int p = 0; p < NP; p++) check(in_out[p], 1'b0, "R9", "in_out during reset");
                step();
                rst = 1'b0;
            end
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule